// File: doc/BRIEF.md
# ARINC 429 Label and SDI Filter

This block sits after an ARINC 429 word receiver and in front of a receive FIFO. For each completed 32-bit word, it decides in a single clock whether the word is written to the FIFO or dropped. The decision uses two checks. The first compares the word's label byte against a programmable table of sixteen 8-bit labels. The second compares ARINC bits 9 and 10 (word bits 8 and 9) against two programmed bits. Each check has its own enable. A dropped word leaves no trace at the outputs.

The label table is filled and inspected through a sequential access mode. A rising edge on the program-mode input rewinds two independent location counters. The host writes that follow store labels into locations 0 to 15 in order. The host reads that follow return those locations in order. While program mode is high, incoming words are discarded.

Top module: `lbl_filter_top`

## Requirements
- R1: After reset, `fifo_wr` and `host_rvld` are 0 and every label location holds 0x00.
- R2: With `cfg_lbl_en`=1, a word is loaded only when `word_data[7:0]` equals one of the 16 stored labels. Host data bit k is compared with word bit k (ARINC bit k+1).
- R3: A stored value of 0x00 matches a word whose label is 0x00, just like any other value; no value marks an empty entry.
- R4: With `cfg_dec_en`=1, a word is loaded only when `word_data[8]`==`cfg_b9` and `word_data[9]`==`cfg_b10`.
- R5: A word is loaded exactly when (`cfg_lbl_en`=0 or the label matches) and (`cfg_dec_en`=0 or the bits match). A load raises `fifo_wr` for one cycle, in the clock after `word_vld`, with `fifo_word` equal to the accepted `word_data`.
- R6: A 0-to-1 change of `cfg_prog` resets the write location to 0. The next 16 `host_wr` pulses store `host_wdata` into locations 0..15 in order. Further writes are ignored until the mode is entered again.
- R7: After the same 0-to-1 change, the next 16 `host_rd` pulses return locations 0..15 in order on `host_rdata`, with `host_rvld` high in the following cycle. Further reads, and reads while `cfg_prog`=0, leave `host_rvld` at 0.
- R8: Any `word_vld` pulse seen while `cfg_prog`=1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | One-cycle strobe: a received word is complete |
| word_data | input | 32 | Received word, bit 0 = ARINC bit 1 |
| cfg_prog | input | 1 | Label table access mode |
| cfg_lbl_en | input | 1 | Label recognition enable |
| cfg_dec_en | input | 1 | Bits 9/10 match enable |
| cfg_b9 | input | 1 | Expected value of ARINC bit 9 |
| cfg_b10 | input | 1 | Expected value of ARINC bit 10 |
| host_wr | input | 1 | Host write strobe for the label table |
| host_wdata | input | 8 | Label to store |
| host_rd | input | 1 | Host read strobe for the label table |
| host_rdata | output | 8 | Label read back |
| host_rvld | output | 1 | `host_rdata` is valid this cycle |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_word | output | 32 | Word to be written to the FIFO |

## Verification
The bench uses the default parameters: a 16-entry table of 8-bit labels and a 32-bit word. At this size, both the sixteenth access and the ignored seventeenth can be reached in a few dozen cycles, as can the rewinding of the counters on re-entry. The table is small enough that the bench can pick labels that are in it, and labels that are not, from a model of the table. A stored 0x00 and the reset contents can both be checked against a label-0 word.

// File: rtl/lbl_filt_pkg.sv
package lbl_filt_pkg;

    localparam int ARINC_LBL_W  = 8;
    localparam int ARINC_WORD_W = 32;

    // Bits 9/10 of the ARINC word sit at word positions 8 and 9
    localparam int SDI_LO = 8;
    localparam int SDI_HI = 9;

    function automatic logic sdi_pass(input logic en, input logic [1:0] bits,
                                      input logic b9, input logic b10);
        return !en || (bits == {b10, b9});
    endfunction

endpackage

// File: rtl/lbl_store.sv
module lbl_store #(
    parameter int N_LBL = 16,
    parameter int LBL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog,
    input  logic             prog_rise,
    input  logic             host_wr,
    input  logic [LBL_W-1:0] host_wdata,
    input  logic             host_rd,
    input  logic [LBL_W-1:0] cmp_lbl,
    output logic             hit,
    output logic [LBL_W-1:0] host_rdata,
    output logic             host_rvld
);
    localparam int CW = $clog2(N_LBL + 1);
    localparam int IW = (N_LBL > 1) ? $clog2(N_LBL) : 1;

    typedef struct packed {
        logic [N_LBL-1:0][LBL_W-1:0] mem;
        logic [CW-1:0]               wr_cnt;
        logic [CW-1:0]               rd_cnt;
        logic [LBL_W-1:0]            rdata;
        logic                        rvld;
    } st_t;

    st_t s_d, s_q;
    logic [CW-1:0]    wr_base, rd_base;
    logic [N_LBL-1:0] eq_vec;

    // One comparator per stored label
    for (genvar g = 0; g < N_LBL; g++) begin : g_cmp
        assign eq_vec[g] = (s_q.mem[g] == cmp_lbl);
    end
    assign hit = |eq_vec;

    always_comb begin
        s_d      = s_q;
        s_d.rvld = 1'b0;
        wr_base  = prog_rise ? '0 : s_q.wr_cnt;
        rd_base  = prog_rise ? '0 : s_q.rd_cnt;
        s_d.wr_cnt = wr_base;
        s_d.rd_cnt = rd_base;
        if (prog && host_wr && (wr_base < CW'(N_LBL))) begin
            s_d.mem[wr_base[IW-1:0]] = host_wdata;
            s_d.wr_cnt = wr_base + CW'(1);
        end
        if (prog && host_rd && (rd_base < CW'(N_LBL))) begin
            s_d.rdata  = s_q.mem[rd_base[IW-1:0]];
            s_d.rvld   = 1'b1;
            s_d.rd_cnt = rd_base + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mem    <= '0;
            s_q.wr_cnt <= CW'(N_LBL);
            s_q.rd_cnt <= CW'(N_LBL);
            s_q.rdata  <= '0;
            s_q.rvld   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rdata = s_q.rdata;
    assign host_rvld  = s_q.rvld;

    // R7
    rd_vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvld |-> ($past(host_rd) && $past(prog)));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wr_cnt <= CW'(N_LBL)) && (s_q.rd_cnt <= CW'(N_LBL)));

endmodule

// File: rtl/word_gate.sv
module word_gate
    import lbl_filt_pkg::*;
#(
    parameter int WORD_W = ARINC_WORD_W
) (
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              prog,
    input  logic              lbl_en,
    input  logic              dec_en,
    input  logic              b9,
    input  logic              b10,
    input  logic              hit,
    output logic              load
);
    logic lbl_ok, sdi_ok;

    always_comb begin
        lbl_ok = !lbl_en || hit;
        sdi_ok = sdi_pass(dec_en, word_data[SDI_HI:SDI_LO], b9, b10);
        load   = word_vld && !prog && lbl_ok && sdi_ok;
    end

endmodule

// File: rtl/lbl_filter_top.sv
module lbl_filter_top
    import lbl_filt_pkg::*;
#(
    parameter int N_LBL  = 16,
    parameter int LBL_W  = ARINC_LBL_W,
    parameter int WORD_W = ARINC_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              cfg_prog,
    input  logic              cfg_lbl_en,
    input  logic              cfg_dec_en,
    input  logic              cfg_b9,
    input  logic              cfg_b10,
    input  logic              host_wr,
    input  logic [LBL_W-1:0]  host_wdata,
    input  logic              host_rd,
    output logic [LBL_W-1:0]  host_rdata,
    output logic              host_rvld,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_word
);
    typedef struct packed {
        logic              prog;
        logic              wr;
        logic [WORD_W-1:0] word;
    } top_st_t;

    top_st_t t_d, t_q;
    logic    prog_rise, hit, load;

    assign prog_rise = cfg_prog && !t_q.prog;

    lbl_store #(.N_LBL(N_LBL), .LBL_W(LBL_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog       (cfg_prog),
        .prog_rise  (prog_rise),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .cmp_lbl    (word_data[LBL_W-1:0]),
        .hit        (hit),
        .host_rdata (host_rdata),
        .host_rvld  (host_rvld)
    );

    word_gate #(.WORD_W(WORD_W)) u_gate (
        .word_vld  (word_vld),
        .word_data (word_data),
        .prog      (cfg_prog),
        .lbl_en    (cfg_lbl_en),
        .dec_en    (cfg_dec_en),
        .b9        (cfg_b9),
        .b10       (cfg_b10),
        .hit       (hit),
        .load      (load)
    );

    always_comb begin
        t_d      = t_q;
        t_d.prog = cfg_prog;
        t_d.wr   = load;
        if (load) t_d.word = word_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign fifo_wr   = t_q.wr;
    assign fifo_word = t_q.word;

    // R8
    no_load_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> ($past(word_vld) && !$past(cfg_prog)));

    // R4
    sdi_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && $past(cfg_dec_en)) |->
            (fifo_word[SDI_HI:SDI_LO] == {$past(cfg_b10), $past(cfg_b9)}));

    // R2
    lbl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && $past(cfg_lbl_en)) |-> $past(hit));

    // R5
    word_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_word == $past(word_data)));

endmodule

// File: tb/tb_lbl_filter_top.sv
module tb_lbl_filter_top;
    localparam int N  = 16;
    localparam int LW = 8;
    localparam int WW = 32;

    logic clk = 0, rst_n = 0;
    logic word_vld = 0, cfg_prog = 0, cfg_lbl_en = 0, cfg_dec_en = 0;
    logic cfg_b9 = 0, cfg_b10 = 0, host_wr = 0, host_rd = 0;
    logic [WW-1:0] word_data = '0;
    logic [LW-1:0] host_wdata = '0;
    logic [LW-1:0] host_rdata;
    logic host_rvld, fifo_wr;
    logic [WW-1:0] fifo_word;

    int checks = 0, failures = 0;
    logic [LW-1:0] ref_mem [N];

    always #5 clk = ~clk;

    lbl_filter_top dut (.*);

    task automatic chk(input logic ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [LW-1:0] l);
        for (int i = 0; i < N; i++) if (ref_mem[i] == l) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic model_load(input logic [WW-1:0] w);
        logic lok, dok;
        lok = !cfg_lbl_en || model_hit(w[LW-1:0]);
        dok = !cfg_dec_en || (w[9:8] == {cfg_b10, cfg_b9});
        return !cfg_prog && lok && dok;
    endfunction

    task automatic send_word(input logic [WW-1:0] w, input string req);
        logic e;
        @(negedge clk);
        word_vld = 1; word_data = w;
        e = model_load(w);
        @(negedge clk);
        word_vld = 0;
        chk(fifo_wr == e, req, {31'd0, fifo_wr}, {31'd0, e});
        if (e) chk(fifo_word == w, req, fifo_word, w);
    endtask

    task automatic wr_label(input logic [LW-1:0] v);
        @(negedge clk); host_wr = 1; host_wdata = v;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd_label(input logic ev, input logic [LW-1:0] ed, input string req);
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
        chk(host_rvld == ev, req, {31'd0, host_rvld}, {31'd0, ev});
        if (ev) chk(host_rdata == ed, req, {24'd0, host_rdata}, {24'd0, ed});
    endtask

    task automatic set_prog(input logic v);
        @(negedge clk); cfg_prog = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [LW-1:0] miss;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(fifo_wr == 0, "R1", {31'd0, fifo_wr}, 0);
        chk(host_rvld == 0, "R1", {31'd0, host_rvld}, 0);
        rst_n = 1;
        // R1: reset contents read back as zero
        set_prog(1);
        for (int i = 0; i < N; i++) rd_label(1, 8'h00, "R1");
        set_prog(0);

        // R6: fill table, entry 5 holds 0x00, 17th write ignored
        set_prog(1);
        for (int i = 0; i < N; i++) begin
            ref_mem[i] = (i == 5) ? 8'h00 : LW'(i * 17 + 3);
            wr_label(ref_mem[i]);
        end
        wr_label(8'hEE);
        // R7: read back in order, 17th read not valid
        for (int i = 0; i < N; i++) rd_label(1, ref_mem[i], "R7 R6");
        rd_label(0, 0, "R7");
        // R8: words dropped while in program mode
        cfg_lbl_en = 0; cfg_dec_en = 0;
        send_word(32'h1234_5678, "R8");
        send_word({24'h0, ref_mem[2]}, "R8");
        set_prog(0);
        rd_label(0, 0, "R7");

        // R2 directed
        cfg_lbl_en = 1;
        send_word({24'hABCDE0, ref_mem[7]}, "R2");
        miss = 8'h01;
        while (model_hit(miss)) miss++;
        send_word({24'h55AA00, miss}, "R2");
        // R3: stored 0x00 matches label 0
        send_word(32'hCAFE_0000, "R3");
        // R4 directed
        cfg_lbl_en = 0; cfg_dec_en = 1; cfg_b9 = 1; cfg_b10 = 0;
        send_word(32'h0000_0100, "R4");
        send_word(32'h0000_0200, "R4");
        send_word(32'h0000_0300, "R4");
        // R5: both checks off, everything loads
        cfg_dec_en = 0;
        send_word(32'hFFFF_FFFF, "R5");

        // R5 random mix
        for (int k = 0; k < 300; k++) begin
            logic [WW-1:0] w;
            cfg_lbl_en = 1'($urandom); cfg_dec_en = 1'($urandom);
            cfg_b9 = 1'($urandom); cfg_b10 = 1'($urandom);
            w = $urandom;
            if ($urandom % 2) w[LW-1:0] = ref_mem[$urandom % N];
            send_word(w, "R5");
        end

        // R6: re-entry rewinds counter, new table without zero
        set_prog(1);
        for (int i = 0; i < N; i++) begin
            ref_mem[i] = LW'(i * 13 + 1);
            wr_label(ref_mem[i]);
        end
        rd_label(1, ref_mem[0], "R6");
        rd_label(1, ref_mem[1], "R6");
        set_prog(0);
        cfg_lbl_en = 1; cfg_dec_en = 0;
        send_word(32'hCAFE_0000, "R3");
        send_word({24'h0, ref_mem[15]}, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule